// File: doc/BRIEF.md
# Interrupt Vector and Low-Power Controller

This block sits next to a small 8-bit CPU core. It collects interrupt requests from three timer events, an external interrupt line and a keyboard line. It tells the core whether an interrupt is pending, and it gives the address of the high byte of the vector to fetch. The low byte is at the next address. Three timer flags are held in a status register, and three enables are held in a control register. Both registers are written over a simple write-only bus.

The block also runs the two sleep modes. A stop request turns off the oscillator, and with it every clock. A wait request gates only the CPU clock, so the timer keeps counting. The two modes accept different sets of wake-up sources. A wake-up always returns the block to run mode, even when the CPU's interrupt mask is set. When the mask is clear, the core then takes the normal vector of the source that woke it.

For one cycle after reset, the block presents the reset vector and asks the core to set its interrupt mask.

Top module: `irq_lowpower_ctrl`

## Requirements
- R1: During the first cycle after reset is released, `vec_addr` is 16'h1FFE and `mask_set` is 1. After that cycle `mask_set` is 0. Reset leaves all flags and enables at 0, all clock enables at 1 and `int_pending` at 0.
- R2: Status register (address 8'h13): bit 7 is the capture flag, bit 6 the compare flag, bit 5 the overflow flag. `tmr_evt[2]`, `tmr_evt[1]` and `tmr_evt[0]` each set their own flag on the next clock edge. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R3: When a flag's event strobe and a write of 1 to that flag arrive in the same cycle, the flag ends up set.
- R4: Control register (address 8'h12): bit 7 enables capture, bit 6 enables compare, bit 5 enables overflow. A timer source makes a request only while both its flag and its enable are 1.
- R5: The vector high-byte address is 16'h0FF6 for capture, 16'h0FF4 for compare, 16'h0FF2 for overflow and 16'h0FFA for an external or keyboard interrupt. When no source requests, it is 16'h1FFE.
- R6: Priority, highest first: external/keyboard, then capture, then compare, then overflow.
- R7: `int_pending` is 1 exactly when some source requests, `cpu_mask` is 0 and the reset cycle is over.
- R8: A stop request in run mode enters stop mode on the next edge, where `osc_en`, `cpu_clk_en` and `tmr_clk_en` are all 0. If stop and wait are requested together, stop wins.
- R9: Only `ext_irq` or `kbd_irq` ends stop mode. Timer requests do not end it.
- R10: A wait request in run mode enters wait mode on the next edge, where `cpu_clk_en` is 0 and both `osc_en` and `tmr_clk_en` stay 1.
- R11: Wait mode returns to run mode on the edge after `ext_irq`, `kbd_irq` or any enabled timer request is seen.
- R12: A wake-up happens even when `cpu_mask` is 1. After such a wake-up the block is in run mode, `int_pending` is 0, and `vec_addr` shows the vector of the source that woke it.
- R13: A bus write to any address other than 8'h12 or 8'h13 changes neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_evt | input | 3 | Timer event strobes: [2] capture, [1] compare, [0] overflow |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 8 | Register write data |
| ext_irq | input | 1 | External interrupt request |
| kbd_irq | input | 1 | Keyboard interrupt request |
| cpu_mask | input | 1 | Interrupt mask bit from the core |
| stop_req | input | 1 | Stop mode request from the core |
| wait_req | input | 1 | Wait mode request from the core |
| int_pending | output | 1 | Unmasked interrupt pending |
| vec_addr | output | 16 | Vector high-byte address |
| mask_set | output | 1 | Tells the core to set its interrupt mask (reset cycle) |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |

## Verification
The assertions assume that `stop_req` and `wait_req` are only raised in run mode. They also assume that an event strobe lasts a single cycle.

The stimulus follows both assumptions. It pulses each request for exactly one cycle from run mode, and it drives every event strobe for one clock.

The checkers do not assume the core obeys the mask. Because of that, the bench freely mixes masked and unmasked wake-ups.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2
  } pmode_e;

  localparam int NTMR = 3;  // [2] capture, [1] compare, [0] overflow

  // flag update: clear by write-1, set by strobe, set wins
  function automatic logic [NTMR-1:0] flag_next(
    input logic [NTMR-1:0] cur,
    input logic [NTMR-1:0] set,
    input logic [NTMR-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  // fixed-priority grant: {ext, capture, compare, overflow}
  function automatic logic [NTMR:0] prio_grant(
    input logic            ext,
    input logic [NTMR-1:0] req
  );
    logic [NTMR:0] g;
    g = '0;
    if (ext)         g[3] = 1'b1;
    else if (req[2]) g[2] = 1'b1;
    else if (req[1]) g[1] = 1'b1;
    else if (req[0]) g[0] = 1'b1;
    return g;
  endfunction

endpackage

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h13,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h12,
  parameter int          FLAG_MSB  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ilp_pkg::NTMR-1:0]  evt,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [ilp_pkg::NTMR-1:0]  flags,
  output logic [ilp_pkg::NTMR-1:0]  enables,
  output logic [ilp_pkg::NTMR-1:0]  req
);
  import ilp_pkg::*;

  localparam int FLAG_LSB = FLAG_MSB - NTMR + 1;

  logic            stat_wr;
  logic            ctrl_wr;
  logic [NTMR-1:0] clr_mask;
  logic [NTMR-1:0] wfield;
  logic            unused_wdata;

  assign stat_wr      = we && (addr == STAT_ADDR);
  assign ctrl_wr      = we && (addr == CTRL_ADDR);
  assign wfield       = wdata[FLAG_MSB:FLAG_LSB];
  assign clr_mask     = stat_wr ? wfield : '0;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= flag_next(flags, evt, clr_mask);
      if (ctrl_wr) enables <= wfield;
    end
  end

  assign req = flags & enables;

  for (genvar i = 0; i < NTMR; i++) begin : g_chk
    // R2
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wfield[i] && !evt[i]) |=> !flags[i]);
    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
  end

  // R13
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(enables));

endmodule

// File: rtl/vec_select.sv
module vec_select #(
  parameter logic [15:0] RST_VEC = 16'h1FFE,
  parameter logic [15:0] EXT_VEC = 16'h0FFA,
  parameter logic [15:0] CAP_VEC = 16'h0FF6,
  parameter logic [15:0] CMP_VEC = 16'h0FF4,
  parameter logic [15:0] OVF_VEC = 16'h0FF2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     boot,
  input  logic                     ext_wake,
  input  logic [ilp_pkg::NTMR-1:0] tmr_req,
  output logic [ilp_pkg::NTMR:0]   grant,
  output logic [15:0]              vec_addr
);
  import ilp_pkg::*;

  assign grant = boot ? '0 : prio_grant(ext_wake, tmr_req);

  always_comb begin
    unique case (1'b1)
      grant[3]: vec_addr = EXT_VEC;
      grant[2]: vec_addr = CAP_VEC;
      grant[1]: vec_addr = CMP_VEC;
      grant[0]: vec_addr = OVF_VEC;
      default:  vec_addr = RST_VEC;
    endcase
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wake && !boot) |-> vec_addr == EXT_VEC);

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_req,
  input  logic            wait_req,
  input  logic            ext_wake,
  input  logic            tmr_wake,
  output ilp_pkg::pmode_e mode,
  output logic            osc_en,
  output logic            cpu_clk_en,
  output logic            tmr_clk_en
);
  import ilp_pkg::*;

  pmode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      PM_RUN: begin
        if (stop_req)      mode_nx = PM_STOP;
        else if (wait_req) mode_nx = PM_WAIT;
      end
      PM_WAIT: if (ext_wake || tmr_wake) mode_nx = PM_RUN;
      PM_STOP: if (ext_wake)             mode_nx = PM_RUN;
      default: mode_nx = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= PM_RUN;
    else        mode <= mode_nx;
  end

  assign osc_en     = (mode != PM_STOP);
  assign tmr_clk_en = (mode != PM_STOP);
  assign cpu_clk_en = (mode == PM_RUN);

  // R8
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN && stop_req) |=> (!osc_en && !tmr_clk_en && !cpu_clk_en));
  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_STOP && !ext_wake) |=> mode == PM_STOP);
  // R10
  wait_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN && wait_req && !stop_req) |=> (!cpu_clk_en && tmr_clk_en && osc_en));
  // R11
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_WAIT && (ext_wake || tmr_wake)) |=> cpu_clk_en);

endmodule

// File: rtl/irq_lowpower_ctrl.sv
module irq_lowpower_ctrl #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h12,
  parameter int          FLAG_MSB  = 7,
  parameter logic [15:0] RST_VEC   = 16'h1FFE,
  parameter logic [15:0] EXT_VEC   = 16'h0FFA,
  parameter logic [15:0] CAP_VEC   = 16'h0FF6,
  parameter logic [15:0] CMP_VEC   = 16'h0FF4,
  parameter logic [15:0] OVF_VEC   = 16'h0FF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        tmr_evt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ext_irq,
  input  logic              kbd_irq,
  input  logic              cpu_mask,
  input  logic              stop_req,
  input  logic              wait_req,
  output logic              int_pending,
  output logic [15:0]       vec_addr,
  output logic              mask_set,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              tmr_clk_en
);
  import ilp_pkg::*;

  logic            boot;
  logic            ext_wake;
  logic            tmr_wake;
  logic [NTMR-1:0] flags;
  logic [NTMR-1:0] enables;
  logic [NTMR-1:0] tmr_req;
  logic [NTMR:0]   grant;
  pmode_e          mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot <= 1'b1;
    else        boot <= 1'b0;
  end

  assign ext_wake = ext_irq | kbd_irq;
  assign tmr_wake = |tmr_req;

  tmr_flag_unit #(
    .AW(ADDR_W), .DW(DATA_W), .STAT_ADDR(STAT_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_MSB(FLAG_MSB)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(tmr_evt), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata),
    .flags(flags), .enables(enables), .req(tmr_req)
  );

  vec_select #(
    .RST_VEC(RST_VEC), .EXT_VEC(EXT_VEC), .CAP_VEC(CAP_VEC),
    .CMP_VEC(CMP_VEC), .OVF_VEC(OVF_VEC)
  ) u_vec (
    .clk(clk), .rst_n(rst_n), .boot(boot), .ext_wake(ext_wake),
    .tmr_req(tmr_req), .grant(grant), .vec_addr(vec_addr)
  );

  sleep_ctrl u_sleep (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wait_req(wait_req),
    .ext_wake(ext_wake), .tmr_wake(tmr_wake), .mode(mode),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en)
  );

  assign mask_set    = boot;
  assign int_pending = !cpu_mask && (|grant);

  // R7
  pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mask || mask_set) |-> !int_pending);
  // R12
  masked_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_WAIT && cpu_mask && (ext_wake || tmr_wake)) |=> mode == PM_RUN);
  // R4
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enables == '0 && !ext_wake) |-> !int_pending);

endmodule

// File: tb/irq_lowpower_ctrl_bench.sv
module irq_lowpower_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tmr_evt = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        ext_irq = 1'b0, kbd_irq = 1'b0, cpu_mask = 1'b0;
  logic        stop_req = 1'b0, wait_req = 1'b0;
  logic        int_pending, mask_set, osc_en, cpu_clk_en, tmr_clk_en;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_lowpower_ctrl u_irq_lowpower_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_evt(tmr_evt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ext_irq(ext_irq),
    .kbd_irq(kbd_irq), .cpu_mask(cpu_mask), .stop_req(stop_req),
    .wait_req(wait_req), .int_pending(int_pending), .vec_addr(vec_addr),
    .mask_set(mask_set), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .tmr_clk_en(tmr_clk_en)
  );

  // {en[2:0], evt[2:0], ext, kbd, mask, exp_pend, exp_vec[15:0]}
  localparam int NV = 10;
  localparam logic [25:0] VECS [NV] = '{
    {3'b111, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0FF6},  // R5 capture
    {3'b111, 3'b010, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0FF4},  // R5 compare
    {3'b111, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0FF2},  // R5 overflow
    {3'b111, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0FF6},  // R6 capture first
    {3'b011, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0FF4},  // R4 R6
    {3'b001, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1FFE},  // R4 no enable
    {3'b111, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0FFA},  // R6 ext first
    {3'b000, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0FFA},  // R5 keyboard
    {3'b111, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0FF6},  // R7 masked
    {3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1FFE}   // R5 idle
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic pulse_evt(input logic [2:0] e);
    tmr_evt = e;
    step();
    tmr_evt = '0;
  endtask

  task automatic chk_clk(input string tag, input logic o, input logic c, input logic t);
    chk({tag, " osc_en"}, {15'd0, osc_en}, {15'd0, o});
    chk({tag, " cpu_clk_en"}, {15'd0, cpu_clk_en}, {15'd0, c});
    chk({tag, " tmr_clk_en"}, {15'd0, tmr_clk_en}, {15'd0, t});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    #1;
    // R1 first cycle after reset
    chk("R1 reset vector", vec_addr, 16'h1FFE);
    chk("R1 mask_set", {15'd0, mask_set}, 16'd1);
    chk("R1 pending", {15'd0, int_pending}, 16'd0);
    chk_clk("R1", 1'b1, 1'b1, 1'b1);
    step();
    chk("R1 mask_set drop", {15'd0, mask_set}, 16'd0);
    wr(8'h12, 8'hE0);
    #1;
    chk("R1 flags clear", {15'd0, int_pending}, 16'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VECS[i];
      wr(8'h13, 8'hE0);
      wr(8'h12, {v[25:23], 5'd0});
      if (v[22:20] != 3'b000) pulse_evt(v[22:20]);
      ext_irq = v[19]; kbd_irq = v[18]; cpu_mask = v[17];
      #1;
      chk($sformatf("R5 R6 R7 entry %0d pend", i), {15'd0, int_pending}, {15'd0, v[16]});
      chk($sformatf("R5 R6 entry %0d vec", i), vec_addr, v[15:0]);
      ext_irq = 1'b0; kbd_irq = 1'b0; cpu_mask = 1'b0;
    end

    // R2 partial clear
    wr(8'h13, 8'hE0);
    wr(8'h12, 8'hE0);
    pulse_evt(3'b110);
    wr(8'h13, 8'h40);
    #1;
    chk("R2 compare cleared only", vec_addr, 16'h0FF6);
    wr(8'h13, 8'h80);
    #1;
    chk("R2 capture cleared", {15'd0, int_pending}, 16'd0);

    // R3 set beats clear
    tmr_evt = 3'b100;
    wr(8'h13, 8'hE0);
    tmr_evt = '0;
    #1;
    chk("R3 set wins", vec_addr, 16'h0FF6);

    // R13 other addresses ignored
    wr(8'h14, 8'hE0);
    wr(8'h11, 8'h00);
    #1;
    chk("R13 foreign write", {15'd0, int_pending}, 16'd1);
    wr(8'h13, 8'hE0);

    // R8 stop wins over wait
    stop_req = 1'b1; wait_req = 1'b1;
    step();
    stop_req = 1'b0; wait_req = 1'b0;
    chk_clk("R8 stop", 1'b0, 1'b0, 1'b0);
    // R9 timer request does not wake stop
    pulse_evt(3'b001);
    step();
    chk_clk("R9 stop holds", 1'b0, 1'b0, 1'b0);
    cpu_mask = 1'b1;
    kbd_irq = 1'b1;
    step();
    kbd_irq = 1'b0;
    chk_clk("R9 keyboard wake", 1'b1, 1'b1, 1'b1);
    cpu_mask = 1'b0;
    wr(8'h13, 8'hE0);

    // R10 wait mode
    wait_req = 1'b1;
    step();
    wait_req = 1'b0;
    chk_clk("R10 wait", 1'b1, 1'b0, 1'b1);
    step();
    chk_clk("R10 wait holds", 1'b1, 1'b0, 1'b1);
    // R11 R12 masked compare wake
    cpu_mask = 1'b1;
    pulse_evt(3'b010);
    chk_clk("R11 flag edge", 1'b1, 1'b0, 1'b1);
    step();
    chk_clk("R11 timer wake", 1'b1, 1'b1, 1'b1);
    chk("R12 masked no pend", {15'd0, int_pending}, 16'd0);
    chk("R12 wake vector", vec_addr, 16'h0FF4);
    cpu_mask = 1'b0;
    #1;
    chk("R12 unmask pend", {15'd0, int_pending}, 16'd1);
    wr(8'h13, 8'hE0);

    // R11 external wake from wait
    wait_req = 1'b1;
    step();
    wait_req = 1'b0;
    ext_irq = 1'b1;
    step();
    chk_clk("R11 ext wake", 1'b1, 1'b1, 1'b1);
    chk("R11 ext vector", vec_addr, 16'h0FFA);
    ext_irq = 1'b0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule